// File: doc/BRIEF.md
# Split Dual 8-bit Auto-Reload Timer

This block holds two independent 8-bit up-counters, a high half and a low half. Each half counts on single-cycle tick enables in the system clock domain. When a half rolls over from its all-ones value, it reloads from its own reload register and sets its own sticky overflow flag. Each half picks its tick source on its own. A per-half select bit chooses either every system clock or the source named by a shared 2-bit external-source field. That field can pick the system clock divided by 12, a real-time clock input divided by 8, or a comparator input. The real-time clock and comparator inputs are asynchronous, so they are synchronized before use.

Software drives the block through a simple write port with four addresses:
- Address 0 holds the control bits.
- Address 1 holds the low-half reload value.
- Address 2 holds the high-half reload value.
- Address 3 clears the flags: writing 1 to bit 0 clears the low flag and writing 1 to bit 1 clears the high flag.

A single level-sensitive interrupt request combines the two flags.

Top module: `split_reload_timer`

## Requirements
- R1: When a half receives a tick while its count is 0xFF, on that clock edge its count becomes its reload value and its overflow flag becomes 1. On any other tick the count increments by one.
- R2: The run bit (control bit 0) gates only the high half. With run at 0 the high count holds. The low half counts whatever the run bit's value.
- R3: A half whose system-clock select bit is 1 counts once on every system clock. Control bit 1 is the select for the high half and bit 2 is the select for the low half.
- R4: With its select bit at 0 and the external-source field (control bits 4:3) at 00, a half counts once every 12 system clocks. Any window of 12·N consecutive cycles gives exactly N counts.
- R5: With field 01, a half counts once per 8 rising edges of the real-time clock input. The divider counts every rising edge since reset, and the 8th, 16th and later edges each produce a count.
- R6: With field 11, a half counts once per rising edge of the comparator input.
- R7: Field value 10 produces no counts for a half whose select bit is 0.
- R8: The overflow flags are never cleared by hardware. A write to address 3 clears the low flag when bit 0 is 1 and the high flag when bit 1 is 1.
- R9: When a clear write and an overflow of the same half land on the same edge, that half's flag ends up at 1.
- R10: The interrupt request equals irq_en AND (high flag OR (low_irq_en AND low flag)). irq_en is control bit 5 and low_irq_en is control bit 6.
- R11: Writing a reload register leaves the current count unchanged. The new value is used at the next overflow.
- R12: After reset both counts, both flags, all control bits and the interrupt request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_in | input | 1 | Asynchronous real-time clock input |
| cmp_in | input | 1 | Asynchronous comparator input |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 low reload, 2 high reload, 3 flag clear |
| wr_data | input | 8 | Write data |
| cnt_lo | output | 8 | Low-half count |
| cnt_hi | output | 8 | High-half count |
| flag_lo | output | 1 | Low-half overflow flag |
| flag_hi | output | 1 | High-half overflow flag |
| irq | output | 1 | Combined interrupt request |

## Verification
- **Write timing.** A write is captured on the edge that samples it, so a new control setting governs ticks from the next edge on. The bench opens a counting window with one control write and closes it with another. The number of enabled edges is exactly the spacing between the two write edges.
- **Count and flag timing.** Counts and flags change on the edge that consumes a tick.
- **Synchronized inputs.** A rising edge on the real-time clock or comparator input becomes a tick three edges after it is applied. The bench therefore leaves at least four idle cycles after the last pulse before closing the window.
- **Interrupt timing.** The interrupt follows the flags and control bits with no added register.
- **Sampling.** All results are sampled at the falling edge after the closing write and compared with a model that advances each half by the tick count computed for that window.

// File: rtl/timer_split_pkg.sv
package timer_split_pkg;

    typedef enum logic [1:0] {
        EXT_DIV12 = 2'b00,
        EXT_RTC8  = 2'b01,
        EXT_NONE  = 2'b10,
        EXT_CMP   = 2'b11
    } ext_sel_e;

    // Bit order matches the control word: bit 0 run_hi ... bit 6 lo_irq_en
    typedef struct packed {
        logic     lo_irq_en;
        logic     irq_en;
        ext_sel_e ext_sel;
        logic     lo_sys;
        logic     hi_sys;
        logic     run_hi;
    } ctrl_t;

    typedef struct packed {
        logic sys;
        logic div12;
        logic rtc8;
        logic cmp;
    } tick_src_t;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RLD_LO = 2'd1;
    localparam logic [1:0] ADDR_RLD_HI = 2'd2;
    localparam logic [1:0] ADDR_CLR    = 2'd3;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic pick_tick(logic use_sys, ext_sel_e sel, tick_src_t s);
        if (use_sys) return s.sys;
        case (sel)
            EXT_DIV12: return s.div12;
            EXT_RTC8:  return s.rtc8;
            EXT_CMP:   return s.cmp;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tsr_sync_edge.sv
module tsr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-1:0], din};
    end

    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/tsr_prescaler.sv
module tsr_prescaler
    import timer_split_pkg::*;
#(
    parameter int SYS_DIV     = 12,
    parameter int RTC_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rtc_in,
    input  logic      cmp_in,
    output tick_src_t src
);
    localparam int SW = $clog2(SYS_DIV);
    localparam int RW = $clog2(RTC_DIV);
    localparam logic [SW-1:0] SYS_LAST = SW'(SYS_DIV - 1);
    localparam logic [RW-1:0] RTC_LAST = RW'(RTC_DIV - 1);

    logic [SW-1:0] sys_cnt_q;
    logic [RW-1:0] rtc_cnt_q;
    logic          rtc_rise;
    logic          cmp_rise;

    tsr_sync_edge #(.STAGES(SYNC_STAGES)) u_rtc_sync (
        .clk(clk), .rst(rst), .din(rtc_in), .rise(rtc_rise)
    );

    tsr_sync_edge #(.STAGES(SYNC_STAGES)) u_cmp_sync (
        .clk(clk), .rst(rst), .din(cmp_in), .rise(cmp_rise)
    );

    always_ff @(posedge clk) begin
        if (rst)                        sys_cnt_q <= '0;
        else if (sys_cnt_q == SYS_LAST) sys_cnt_q <= '0;
        else                            sys_cnt_q <= sys_cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) rtc_cnt_q <= '0;
        else if (rtc_rise) begin
            if (rtc_cnt_q == RTC_LAST) rtc_cnt_q <= '0;
            else                       rtc_cnt_q <= rtc_cnt_q + 1'b1;
        end
    end

    always_comb begin
        src.sys   = 1'b1;
        src.div12 = (sys_cnt_q == SYS_LAST);
        src.rtc8  = rtc_rise && (rtc_cnt_q == RTC_LAST);
        src.cmp   = cmp_rise;
    end
endmodule

// File: rtl/tsr_half.sv
module tsr_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign wrap = tick && (cnt_q == {W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (wrap) cnt_q <= reload;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
    import timer_split_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYS_DIV     = 12,
    parameter int RTC_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rtc_in,
    input  logic             cmp_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_lo,
    output logic [CNT_W-1:0] cnt_hi,
    output logic             flag_lo,
    output logic             flag_hi,
    output logic             irq
);
    localparam int HALVES = 2;

    ctrl_t                         ctrl_q;
    tick_src_t                     src;
    logic [HALVES-1:0]             tick_v;
    logic [HALVES-1:0]             wrap_v;
    logic [HALVES-1:0]             flag_v;
    logic [HALVES-1:0][CNT_W-1:0]  cnt_v;
    logic [HALVES-1:0][CNT_W-1:0]  reload_v;

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    tsr_prescaler #(
        .SYS_DIV(SYS_DIV), .RTC_DIV(RTC_DIV), .SYNC_STAGES(SYNC_STAGES)
    ) u_pre (
        .clk(clk), .rst(rst), .rtc_in(rtc_in), .cmp_in(cmp_in), .src(src)
    );

    // Index 0 is the low half, index 1 the high half
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        localparam bit IS_HI = (h == 1);
        localparam logic [1:0] RLD_ADDR = IS_HI ? ADDR_RLD_HI : ADDR_RLD_LO;

        logic [CNT_W-1:0] reload_q;
        logic             flag_q;
        logic             use_sys;
        logic             gate;

        assign use_sys   = IS_HI ? ctrl_q.hi_sys : ctrl_q.lo_sys;
        assign gate      = IS_HI ? ctrl_q.run_hi : 1'b1;
        assign tick_v[h] = gate & pick_tick(use_sys, ctrl_q.ext_sel, src);

        always_ff @(posedge clk) begin
            if (rst) reload_q <= '0;
            else if (wr_en && wr_addr == RLD_ADDR) reload_q <= wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst)                                           flag_q <= 1'b0;
            else if (wrap_v[h])                                flag_q <= 1'b1;
            else if (wr_en && wr_addr == ADDR_CLR && wr_data[h]) flag_q <= 1'b0;
        end

        assign reload_v[h] = reload_q;
        assign flag_v[h]   = flag_q;

        tsr_half #(.W(CNT_W)) u_half (
            .clk(clk), .rst(rst), .tick(tick_v[h]), .reload(reload_q),
            .cnt(cnt_v[h]), .wrap(wrap_v[h])
        );
    end

    assign cnt_lo  = cnt_v[0];
    assign cnt_hi  = cnt_v[1];
    assign flag_lo = flag_v[0];
    assign flag_hi = flag_v[1];
    assign irq     = ctrl_q.irq_en & (flag_v[1] | (ctrl_q.lo_irq_en & flag_v[0]));
endmodule

// File: rtl/split_reload_timer_chk.sv
module split_reload_timer_chk
    import timer_split_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input ctrl_t            ctrl,
    input logic             tick_lo,
    input logic             tick_hi,
    input logic [CNT_W-1:0] reload_lo,
    input logic [CNT_W-1:0] reload_hi,
    input logic [CNT_W-1:0] cnt_lo,
    input logic [CNT_W-1:0] cnt_hi,
    input logic             flag_lo,
    input logic             flag_hi,
    input logic             irq
);
    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

    a_r1_reload_hi: assert property (@(posedge clk) disable iff (rst)
        (tick_hi && cnt_hi == ALL1) |=> (cnt_hi == $past(reload_hi)) && flag_hi);

    a_r1_reload_lo: assert property (@(posedge clk) disable iff (rst)
        (tick_lo && cnt_lo == ALL1) |=> (cnt_lo == $past(reload_lo)) && flag_lo);

    a_r2_hi_holds: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run_hi |=> $stable(cnt_hi));

    a_r3_lo_every_clock: assert property (@(posedge clk) disable iff (rst)
        (ctrl.lo_sys && cnt_lo != ALL1) |=> cnt_lo == $past(cnt_lo) + 1'b1);

    a_r7_reserved_lo: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.lo_sys && ctrl.ext_sel == EXT_NONE) |=> $stable(cnt_lo));

    a_r8_sticky_hi: assert property (@(posedge clk) disable iff (rst)
        (flag_hi && !(wr_en && wr_addr == ADDR_CLR && wr_data[1])) |=> flag_hi);

    a_r9_wrap_beats_clear_lo: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_CLR && wr_data[0] && tick_lo && cnt_lo == ALL1) |=> flag_lo);

    a_r10_irq_hi: assert property (@(posedge clk) disable iff (rst)
        (ctrl.irq_en && flag_hi) |-> irq);

    a_r10_irq_off: assert property (@(posedge clk) disable iff (rst)
        !ctrl.irq_en |-> !irq);

    a_r12_reset: assert property (@(posedge clk)
        rst |=> (cnt_lo == '0) && (cnt_hi == '0) && !flag_lo && !flag_hi && !irq);
endmodule

bind split_reload_timer split_reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl_q), .tick_lo(tick_v[0]), .tick_hi(tick_v[1]),
    .reload_lo(reload_v[0]), .reload_hi(reload_v[1]),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .flag_lo(flag_lo), .flag_hi(flag_hi), .irq(irq)
);

// File: tb/split_reload_timer_bench.sv
module split_reload_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rtc_in = 1'b0;
    logic       cmp_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] cnt_lo, cnt_hi;
    logic       flag_lo, flag_hi, irq;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [7:0] m_cnt_lo, m_cnt_hi, m_rld_lo, m_rld_hi;
    logic       m_flag_lo, m_flag_hi;
    int         rtc_total;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_reload_timer u_split_reload_timer (
        .clk(clk), .rst(rst), .rtc_in(rtc_in), .cmp_in(cmp_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .flag_lo(flag_lo), .flag_hi(flag_hi), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] ctrl_word(logic run, logic hs, logic ls, logic [1:0] ext,
                                             logic ie, logic lie);
        return {1'b0, lie, ie, ext, ls, hs, run};
    endfunction

    // Advance a half by n ticks; bit 8 reports any overflow
    function automatic logic [8:0] adv(logic [7:0] c, logic [7:0] r, int n);
        logic ovf = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (c == 8'hFF) begin c = r; ovf = 1'b1; end
            else c = c + 8'd1;
        end
        return {ovf, c};
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt_lo = 0; m_cnt_hi = 0; m_rld_lo = 0; m_rld_hi = 0;
        m_flag_lo = 0; m_flag_hi = 0; rtc_total = 0;
    endtask

    task automatic cmp_all(input string tag);
        chk({tag, " cnt_lo"}, cnt_lo, m_cnt_lo);
        chk({tag, " cnt_hi R2"}, cnt_hi, m_cnt_hi);
        chk("R1 R8 flag_lo", flag_lo, m_flag_lo);
        chk("R1 R8 flag_hi", flag_hi, m_flag_hi);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [8:0] r;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R12 reset state
        chk("R12 cnt_lo", cnt_lo, 0);
        chk("R12 cnt_hi", cnt_hi, 0);
        chk("R12 flag_lo", flag_lo, 0);
        chk("R12 flag_hi", flag_hi, 0);
        chk("R12 irq", irq, 0);

        // R11 reload write leaves count alone
        wr(2'd2, 8'h55);
        chk("R11 cnt_hi after reload write", cnt_hi, 0);

        // R2 high half held with run=0 while fast-selected
        wr(2'd0, ctrl_word(1'b0, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0));
        repeat (20) @(negedge clk);
        chk("R2 cnt_hi held", cnt_hi, 0);

        // R3 high half with run=1: 10 enabled edges
        wr(2'd0, ctrl_word(1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0));
        repeat (9) @(negedge clk);
        wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0));
        chk("R3 cnt_hi ten ticks", cnt_hi, 10);

        // R2 low half runs with run=0: 5 enabled edges
        wr(2'd0, ctrl_word(1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0));
        repeat (4) @(negedge clk);
        wr(2'd0, ctrl_word(1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0));
        chk("R2 cnt_lo runs without run", cnt_lo, 5);
        chk("R2 cnt_hi still", cnt_hi, 10);

        // R9 / R8 overflow versus clear
        wr(2'd1, 8'hFE);
        wr(2'd0, ctrl_word(1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0));
        while (cnt_lo != 8'hFF) @(negedge clk);
        wr(2'd3, 8'h01);
        chk("R9 flag_lo kept on same-edge clear", flag_lo, 1);
        chk("R1 cnt_lo reloaded", cnt_lo, 8'hFE);
        wr(2'd3, 8'h01);
        chk("R8 flag_lo cleared by write", flag_lo, 0);
        @(negedge clk);
        chk("R1 flag_lo set again", flag_lo, 1);
        wr(2'd0, ctrl_word(1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0));
        chk("R10 low flag ignored without low enable", irq, 0);
        wr(2'd0, ctrl_word(1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1));
        chk("R10 low flag raises irq", irq, 1);

        // Random segments against the model
        do_reset();
        for (int seg = 0; seg < 60; seg++) begin
            logic [1:0] ext;
            logic       run, hs, ls, ie, lie;
            int         k, p, n_src, n_lo, n_hi;
            string      tag;
            ext = 2'($urandom_range(0, 3));
            run = 1'($urandom_range(0, 1));
            hs  = ($urandom_range(0, 3) == 0);
            ls  = ($urandom_range(0, 3) == 0);
            ie  = 1'($urandom_range(0, 1));
            lie = 1'($urandom_range(0, 1));
            p = 0;
            if ($urandom_range(0, 2) == 0) begin
                m_rld_lo = 8'($urandom_range(0, 255)); wr(2'd1, m_rld_lo);
            end
            if ($urandom_range(0, 2) == 0) begin
                m_rld_hi = 8'($urandom_range(0, 255)); wr(2'd2, m_rld_hi);
            end
            if ($urandom_range(0, 2) == 0) begin
                logic [7:0] cb;
                cb = 8'($urandom_range(0, 3));
                wr(2'd3, cb);
                if (cb[0]) m_flag_lo = 1'b0;
                if (cb[1]) m_flag_hi = 1'b0;
            end
            case (ext)
                2'b00: begin k = 12 * $urandom_range(1, 20); n_src = k / 12; tag = "R4"; end
                2'b01: begin
                    p = $urandom_range(1, 20); k = 4 * p + 6;
                    n_src = (rtc_total + p) / 8 - rtc_total / 8;
                    rtc_total += p; tag = "R5";
                end
                2'b11: begin p = $urandom_range(1, 20); k = 4 * p + 6; n_src = p; tag = "R6"; end
                default: begin k = $urandom_range(1, 300); n_src = 0; tag = "R7"; end
            endcase
            n_lo = ls ? k : n_src;
            n_hi = run ? (hs ? k : n_src) : 0;
            if (ls || hs) tag = {tag, " R3"};
            wr(2'd0, ctrl_word(run, hs, ls, ext, ie, lie));
            for (int i = 0; i < k - 1; i++) begin
                logic lvl;
                lvl = (i < 4 * p) && ((i % 4) < 2);
                rtc_in = (ext == 2'b01) ? lvl : 1'b0;
                cmp_in = (ext == 2'b11) ? lvl : 1'b0;
                @(negedge clk);
            end
            rtc_in = 1'b0; cmp_in = 1'b0;
            wr(2'd0, ctrl_word(run, 1'b0, 1'b0, 2'b10, ie, lie));
            r = adv(m_cnt_lo, m_rld_lo, n_lo);
            m_cnt_lo = r[7:0]; m_flag_lo = m_flag_lo | r[8];
            r = adv(m_cnt_hi, m_rld_hi, n_hi);
            m_cnt_hi = r[7:0]; m_flag_hi = m_flag_hi | r[8];
            cmp_all({tag, " R1 R11"});
            chk("R10 irq", irq, ie & (m_flag_hi | (lie & m_flag_lo)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule